// File: doc/BRIEF.md
# Clock Ready Flag and Interrupt Unit

This block is the status and interrupt register unit of a clock controller. It watches the stable levels of five clock sources: the low-speed internal and external oscillators, the high-speed internal and external oscillators, and the PLL. It also watches a strobe from a clock-failure detector. Each rising stable level is latched as a pending flag. Each ready flag is masked by its own enable. The unit drives one combined interrupt line, and a detected clock failure always raises that line.

A second register keeps the causes of the latest resets: external pin, power-on, software, independent watchdog, window watchdog and low-power. Software clears all of them at once with one command bit. That bit reads back as busy until the clear has finished.

Software reaches the unit through a plain 32-bit register port. A write happens in the cycle where `reg_wr` is high. Read data is combinational from `reg_addr`. The port has no back-pressure: every write takes effect at the next clock edge. The oscillators, the failure detector and the reset generator are outside the block and appear only as input levels and pulses.

Top module: `clkrdy_irq_unit`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `fail_det_en` is 0.
- R2: Ready flag bit i of register 0 (bit 0 low-speed internal, 1 low-speed external, 2 high-speed internal, 3 high-speed external, 4 PLL) is set by the clock edge at which `src_stable[i]` is first seen high after being low. A level that stays high does not set the flag again after it has been cleared.
- R3: Writing 1 to bit 16+i of register 0 clears ready flag i, and writing 1 to bit 23 clears the failure flag. Clear bits read back as 0, and writing 0 to a clear bit has no effect.
- R4: When a flag's set event and its clear write fall on the same edge, the flag stays set.
- R5: Bits 12:8 of register 0 are the ready enables, written together as a field. `irq` is 1 exactly when some ready flag and its enable are both 1, or when the failure flag is 1.
- R6: The failure flag (register 0 bit 7) is set on a rising edge of `clk_fail` only while detection is enabled. It raises `irq` whatever the enables hold.
- R7: Writing 0x009F0000 to register 0 clears all flags and all enables at once.
- R8: Register 1 bits 5:0 latch single-cycle reset-cause pulses. The bit order is pin, power-on, software, independent watchdog, window watchdog, low-power. Writes to those bits are ignored.
- R9: Writing 1 to register 1 bit 24 starts a clear. Bit 24 reads 1 for the next two cycles, then returns to 0 with bits 5:0 cleared.
- R10: A reset-cause pulse that arrives on the final edge of a clear is kept.
- R11: Register 2 bit 0 enables failure detection. It is driven out on `fail_det_en` and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 interrupt, 1 reset cause, 2 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_stable | input | 5 | Stable levels of the five clock sources |
| clk_fail | input | 1 | Clock-failure strobe from the detector |
| rst_cause | input | 6 | Single-cycle reset-cause pulses |
| fail_det_en | output | 1 | Failure-detection enable to the detector |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. A set event beats a same-edge clear. A clear alone drops the flag. A rising stable level under arming produces a flag. Any enabled flag or the failure flag forces the interrupt. The clear-command bit stays high for exactly two cycles and leaves only the pulses of its final edge.

Other behaviour can only be shown by the bench's scenarios. This covers the register field layout, the combined 0x009F0000 write, the fact that ignored writes really leave state untouched, and the gating of the failure flag by the detection enable. Long random runs compare every readback against a reference model.

// File: rtl/ckr_pkg.sv
package ckr_pkg;
  localparam int NUM_RDY   = 5;
  localparam int NUM_CAUSE = 6;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] A_INT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RST  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  localparam int FAIL_FLAG_POS = 7;
  localparam int EN_LSB        = 8;
  localparam int CLR_LSB       = 16;
  localparam int FAIL_CLR_POS  = 23;
  localparam int RCLR_POS      = 24;
  localparam int CFD_POS       = 0;
endpackage

// File: rtl/ckr_flag_cell.sv
module ckr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic arm,
  input  logic clr,
  output logic flag
);
  logic prev;
  logic set_ev;

  assign set_ev = arm & lvl & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= lvl;
      flag <= set_ev | (flag & ~clr);
    end
  end

  // R4: set beats clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr) |=> flag);
  // R3: lone clear drops flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_ev) |=> !flag);
  // R2: armed rising level latches
  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && $rose(lvl)) |=> flag);
endmodule

// File: rtl/ckr_rstcause.sv
module ckr_rstcause #(
  parameter int NCAUSE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCAUSE-1:0] cause,
  output logic [NCAUSE-1:0] flags,
  output logic              busy
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      busy  <= 1'b0;
      phase <= 1'b0;
    end else if (busy && phase) begin
      flags <= cause;
      busy  <= 1'b0;
      phase <= 1'b0;
    end else begin
      flags <= flags | cause;
      if (busy) begin
        phase <= 1'b1;
      end else if (start) begin
        busy  <= 1'b1;
        phase <= 1'b0;
      end
    end
  end

  // R9: busy holds for a second cycle after it rises
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  // R9: busy never lasts beyond two cycles
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);
  // R10: after the clear only the last-edge pulses remain
  p_clear_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (flags == $past(cause)));
endmodule

// File: rtl/clkrdy_irq_unit.sv
module clkrdy_irq_unit
  import ckr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [4:0]  src_stable,
  input  logic        clk_fail,
  input  logic [5:0]  rst_cause,
  output logic        fail_det_en,
  output logic        irq
);
  localparam int NSRC = NUM_RDY + 1;

  logic                 wr_int, wr_rst, wr_ctrl;
  logic [NUM_RDY-1:0]   int_en;
  logic                 cfd_q;
  logic [NSRC-1:0]      lvl_vec, arm_vec, clr_vec, flag_vec;
  logic [NUM_CAUSE-1:0] cause_flags;
  logic                 rclr_busy;

  assign wr_int  = reg_wr && (reg_addr == A_INT);
  assign wr_rst  = reg_wr && (reg_addr == A_RST);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  assign lvl_vec = {clk_fail, src_stable};
  assign arm_vec = {cfd_q, {NUM_RDY{1'b1}}};
  assign clr_vec = wr_int ? {reg_wdata[FAIL_CLR_POS], reg_wdata[CLR_LSB +: NUM_RDY]}
                          : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    ckr_flag_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl_vec[g]),
      .arm  (arm_vec[g]),
      .clr  (clr_vec[g]),
      .flag (flag_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en <= '0;
      cfd_q  <= 1'b0;
    end else begin
      if (wr_int)  int_en <= reg_wdata[EN_LSB +: NUM_RDY];
      if (wr_ctrl) cfd_q  <= reg_wdata[CFD_POS];
    end
  end

  ckr_rstcause #(.NCAUSE(NUM_CAUSE)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .start(wr_rst && reg_wdata[RCLR_POS]),
    .cause(rst_cause),
    .flags(cause_flags),
    .busy (rclr_busy)
  );

  assign irq         = (|(flag_vec[NUM_RDY-1:0] & int_en)) | flag_vec[NUM_RDY];
  assign fail_det_en = cfd_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_INT: begin
        reg_rdata[NUM_RDY-1:0]           = flag_vec[NUM_RDY-1:0];
        reg_rdata[FAIL_FLAG_POS]         = flag_vec[NUM_RDY];
        reg_rdata[EN_LSB +: NUM_RDY]     = int_en;
      end
      A_RST: begin
        reg_rdata[NUM_CAUSE-1:0] = cause_flags;
        reg_rdata[RCLR_POS]      = rclr_busy;
      end
      A_CTRL: reg_rdata[CFD_POS] = cfd_q;
      default: reg_rdata = '0;
    endcase
  end

  // R6: failure flag always interrupts
  p_fail_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_vec[NUM_RDY] |-> irq);
  // R5: an enabled ready flag interrupts
  p_enabled_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_vec[NUM_RDY-1:0] & int_en) != '0) |-> irq);
  // R6: disarmed detector cannot raise the failure flag
  p_fail_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfd_q && !flag_vec[NUM_RDY]) |=> !flag_vec[NUM_RDY]);
endmodule

// File: tb/clkrdy_irq_unit_bench.sv
module clkrdy_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  src_stable = '0;
  logic        clk_fail = 1'b0;
  logic [5:0]  rst_cause = '0;
  logic        fail_det_en, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  clkrdy_irq_unit u_clkrdy_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_stable(src_stable),
    .clk_fail(clk_fail), .rst_cause(rst_cause), .fail_det_en(fail_det_en), .irq(irq)
  );

  // reference model built from the requirements
  logic [5:0] m_prev, m_flag, m_rf;
  logic [4:0] m_en;
  logic       m_cfd, m_busy, m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_flag = '0; m_rf = '0; m_en = '0;
      m_cfd = 0; m_busy = 0; m_ph = 0;
    end else begin
      logic [5:0] clr, set;
      clr = (reg_wr && reg_addr == 2'd0) ? {reg_wdata[23], reg_wdata[20:16]} : 6'd0;
      set = {m_cfd & clk_fail & ~m_prev[5], src_stable & ~m_prev[4:0]};
      m_flag = set | (m_flag & ~clr);
      m_prev = {clk_fail, src_stable};
      if (m_busy && m_ph) begin
        m_rf = rst_cause; m_busy = 0; m_ph = 0;
      end else begin
        m_rf = m_rf | rst_cause;
        if (m_busy) m_ph = 1;
        else if (reg_wr && reg_addr == 2'd1 && reg_wdata[24]) begin m_busy = 1; m_ph = 0; end
      end
      if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[12:8];
      if (reg_wr && reg_addr == 2'd2) m_cfd = reg_wdata[0];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {19'd0, m_en, m_flag[5], 2'd0, m_flag[4:0]};
      2'd1:    return {7'd0, m_busy, 18'd0, m_rf};
      2'd2:    return {31'd0, m_cfd};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_flag[4:0] & m_en)) | m_flag[5];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 32'h0, "R1 int"); rd(1, 32'h0, "R1 rst"); rd(2, 32'h0, "R1 ctrl");
    chk("R1 irq", irq, 0); chk("R1 fail_det_en", fail_det_en, 0);
    // R2 rising stable level
    src_stable = 5'b00100; tick();
    rd(0, 32'h4, "R2 flag set"); chk("R5 masked irq", irq, 0);
    wr(0, 32'h00000400);
    chk("R5 enabled irq", irq, 1); rd(0, 32'h404, "R5 enable field");
    // R3 clear
    wr(0, 32'h00040400);
    rd(0, 32'h400, "R3 cleared"); chk("R3 irq drop", irq, 0);
    tick(); rd(0, 32'h400, "R2 held level no reset");
    // R4 set and clear on same edge
    src_stable[0] = 1; wr(0, 32'h00010400);
    rd(0, 32'h401, "R4 set wins");
    wr(0, 32'h00000400); rd(0, 32'h401, "R3 zero clear no effect");
    // R6 failure gating
    clk_fail = 1; tick(); clk_fail = 0;
    rd(0, 32'h401, "R6 disarmed");
    wr(2, 32'h1); chk("R11 enable out", fail_det_en, 1);
    wr(0, 32'h0); chk("R5 no enables", irq, 0);
    clk_fail = 1; tick(); clk_fail = 0;
    rd(0, 32'h081, "R6 fail flag"); chk("R6 fail irq", irq, 1);
    // R7 combined clear
    wr(0, 32'h009F0000);
    rd(0, 32'h0, "R7 all clear"); chk("R7 irq", irq, 0);
    // R8 reset causes
    rst_cause = 6'b100101; tick(); rst_cause = 0;
    rd(1, 32'h25, "R8 latch");
    // R9 / R10 clear sequence
    wr(1, 32'h01000000); rd(1, 32'h01000025, "R9 busy first");
    tick(); rd(1, 32'h01000025, "R9 busy second");
    rst_cause = 6'b000010; tick(); rst_cause = 0;
    rd(1, 32'h2, "R10 late pulse kept");
    wr(1, 32'h0000003F); rd(1, 32'h2, "R8 write ignored");
    wr(2, 32'h0); chk("R11 disable out", fail_det_en, 0);
    src_stable = 0; tick();
    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 5; b++) if ($urandom % 8 == 0) src_stable[b] = ~src_stable[b];
      clk_fail = ($urandom % 12 == 0);
      for (int b = 0; b < 6; b++) rst_cause[b] = ($urandom % 40 == 0);
      reg_wr = ($urandom % 5 == 0);
      reg_addr = 2'($urandom % 4);
      reg_wdata = $urandom;
      if (reg_addr == 2'd1 && ($urandom % 4 != 0)) reg_wdata[24] = 0;
      tick(); #1;
      chk("R2 R3 R8 model readback", reg_rdata, exp_rd(reg_addr));
      chk("R5 R6 model irq", irq, exp_irq());
      chk("R11 model enable", fail_det_en, m_cfd);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule